// File: doc/BRIEF.md
# Processor Interrupt Presentation Unit

This unit sits beside one processor core and decides which interrupt, if any, that core should see. It holds a current priority threshold for the core, one captured external request (vector plus priority) taken from a source-side port, and a software-written inter-processor request priority. When a held request is more favored than the threshold, the unit raises its interrupt line to the core. A numerically lower priority value is more favored.

Software talks to the unit over a small 32-bit register bus with byte enables. The presentation word packs the threshold in the top byte and the vector in the low 24 bits. Reading this word at the accept offset claims the interrupt. That read returns the old threshold, moves the threshold to the claimed priority and retires the pending request. Writing a full word to the same offset ends the interrupt. The top byte becomes the new threshold, and a normal vector is handed back to the source side as a one-cycle strobe.

A second offset returns the same word without any side effect, so software can peek. The inter-processor request lives in its own priority register and is always presented as vector 2. Vector 0 means nothing to present.

Top module: `ext_irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, the inter-processor register holds 0xFF, nothing is pending, the interrupt line is low, and the poll word reads 0x00000000.
- R2: `src_ready` is high exactly while no external request is held. A `src_req` pulse while ready captures `src_vec` and `src_prio`. A request made while one is held is ignored and leaves the held vector unchanged.
- R3: A request is eligible only when its priority is numerically lower than the threshold. Equal or higher values are not eligible. `irq_out` is high exactly when some request is eligible.
- R4: A read at byte offset 0x0 returns {threshold[31:24], vector[23:0]}, where the vector is the winning eligible vector or 0 if none is eligible. It changes no state.
- R5: A read at byte offset 0x4 returns the same word as R4. If a request was eligible, the threshold then becomes that request's priority, and the request is retired: an external one is cleared, an inter-processor one is marked in service.
- R6: An accept read with nothing eligible returns vector 0 and changes no state.
- R7: A write at offset 0x4 with byte enables 4'b1000 sets only the threshold from wdata[31:24]. Writes at 0x4 with byte enables other than 4'b1000 and 4'b1111 are ignored.
- R8: A write at offset 0xC with byte enable bit 3 set stores wdata[31:24] as the inter-processor priority. Any value other than 0xFF requests vector 2 at that priority. 0xFF withdraws the request.
- R9: When the external and the inter-processor requests are both eligible, the lower priority value wins. On a tie the inter-processor request wins.
- R10: A write at offset 0x4 with all byte enables is an end-of-interrupt. The threshold takes wdata[31:24]. Vector 2 in wdata[23:0] clears the in-service mark. Any other nonzero vector pulses `eoi_valid` for one cycle, one clock after the write, with `eoi_vec` equal to that vector. Vectors 0 and 2 produce no pulse.
- R11: While the inter-processor request is in service it is not presented, even if its register still holds a favored value. It is presented again after an end-of-interrupt for vector 2.
- R12: Every read is answered one clock later with `bus_rvalid` high for one cycle and the data on `bus_rdata`. Reads at unmapped offsets return 0. Offset 0xC reads as {priority, 24'h0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_be | input | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| src_req | input | 1 | External request strobe |
| src_vec | input | 24 | External request vector |
| src_prio | input | 8 | External request priority |
| src_ready | output | 1 | No external request held |
| eoi_valid | output | 1 | End-of-interrupt strobe to the source side |
| eoi_vec | output | 24 | Vector being finished |
| irq_out | output | 1 | Interrupt line to the core |

## Verification
The hardest state to reach is an inter-processor request that is in service while its priority register still holds a favored value and an external request is waiting below it. To get there, the stimulus loads both requests and claims the inter-processor one first. It then lowers the threshold to expose the external request, claims that too, and ends the two interrupts out of order. This shows that vector 2 stays hidden until its own end-of-interrupt and then returns. Tie and ordering cases are reached by moving the inter-processor priority around one held external request without claiming it.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_POLL,
        OP_ACCEPT,
        OP_RD_QIRR,
        OP_RD_OTHER,
        OP_SET_CPPR,
        OP_EOI,
        OP_SET_QIRR
    } bus_op_e;

endpackage

// File: rtl/ipu_bus_decode.sv
module ipu_bus_decode
    import ipu_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int POLL_OFF = 0,
    parameter int XIRR_OFF = 4,
    parameter int QIRR_OFF = 12
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output bus_op_e           op
);
    localparam logic [ADDR_W-1:0] A_POLL = ADDR_W'(POLL_OFF);
    localparam logic [ADDR_W-1:0] A_XIRR = ADDR_W'(XIRR_OFF);
    localparam logic [ADDR_W-1:0] A_QIRR = ADDR_W'(QIRR_OFF);

    always_comb begin
        op = OP_NONE;
        if (req && !we) begin
            if (addr == A_POLL)      op = OP_POLL;
            else if (addr == A_XIRR) op = OP_ACCEPT;
            else if (addr == A_QIRR) op = OP_RD_QIRR;
            else                     op = OP_RD_OTHER;
        end else if (req && we) begin
            if (addr == A_XIRR) begin
                if (be == 4'b1111)      op = OP_EOI;
                else if (be == 4'b1000) op = OP_SET_CPPR;
            end else if (addr == A_QIRR && be[3]) begin
                op = OP_SET_QIRR;
            end
        end
    end
endmodule

// File: rtl/ipu_arbiter.sv
module ipu_arbiter #(
    parameter int PRIO_W       = 8,
    parameter int VEC_W        = 24,
    parameter int IPI_VEC      = 2,
    parameter bit IPI_WINS_TIE = 1'b1
) (
    input  logic [PRIO_W-1:0] cppr,
    input  logic              ext_pend,
    input  logic [PRIO_W-1:0] ext_prio,
    input  logic [VEC_W-1:0]  ext_vec,
    input  logic [PRIO_W-1:0] qirr,
    input  logic              ipi_busy,
    output logic              win_valid,
    output logic              win_is_ipi,
    output logic [PRIO_W-1:0] win_prio,
    output logic [VEC_W-1:0]  win_vec
);
    localparam logic [PRIO_W-1:0] LEAST = '1;
    localparam logic [VEC_W-1:0]  IPI_V = VEC_W'(IPI_VEC);

    logic ext_ok;
    logic ipi_ok;
    logic ipi_beats_ext;

    assign ext_ok = ext_pend && (ext_prio < cppr);
    assign ipi_ok = !ipi_busy && (qirr != LEAST) && (qirr < cppr);

    generate
        if (IPI_WINS_TIE) begin : g_tie_ipi
            assign ipi_beats_ext = (qirr <= ext_prio);
        end else begin : g_tie_ext
            assign ipi_beats_ext = (qirr < ext_prio);
        end
    endgenerate

    always_comb begin
        win_valid  = ext_ok || ipi_ok;
        win_is_ipi = ipi_ok && (!ext_ok || ipi_beats_ext);
        win_prio   = win_is_ipi ? qirr : ext_prio;
        win_vec    = win_is_ipi ? IPI_V : ext_vec;
    end
endmodule

// File: rtl/ipu_core.sv
module ipu_core
    import ipu_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int VEC_W   = 24,
    parameter int IPI_VEC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  bus_op_e                 op,
    input  logic [PRIO_W+VEC_W-1:0] wdata,
    input  logic                    src_req,
    input  logic [VEC_W-1:0]        src_vec,
    input  logic [PRIO_W-1:0]       src_prio,
    input  logic                    win_valid,
    input  logic                    win_is_ipi,
    input  logic [PRIO_W-1:0]       win_prio,
    input  logic [VEC_W-1:0]        win_vec,
    output logic [PRIO_W-1:0]       cppr,
    output logic [PRIO_W-1:0]       qirr,
    output logic                    ipi_busy,
    output logic                    pend,
    output logic [PRIO_W-1:0]       pend_prio,
    output logic [VEC_W-1:0]        pend_vec,
    output logic [PRIO_W+VEC_W-1:0] rdata,
    output logic                    rvalid,
    output logic                    eoi_valid,
    output logic [VEC_W-1:0]        eoi_vec
);
    localparam int WORD_W = PRIO_W + VEC_W;
    localparam logic [VEC_W-1:0] IPI_V = VEC_W'(IPI_VEC);

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [PRIO_W-1:0] qirr;
        logic              ipi_busy;
        logic              pend;
        logic [PRIO_W-1:0] pprio;
        logic [VEC_W-1:0]  pvec;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
        logic              eoi_valid;
        logic [VEC_W-1:0]  eoi_vec;
    } state_t;

    state_t s_d, s_q;
    logic [WORD_W-1:0] pres_word;
    logic [PRIO_W-1:0] wr_top;
    logic [VEC_W-1:0]  wr_vec;

    assign pres_word = {s_q.cppr, (win_valid ? win_vec : {VEC_W{1'b0}})};
    assign wr_top    = wdata[WORD_W-1:VEC_W];
    assign wr_vec    = wdata[VEC_W-1:0];

    always_comb begin
        s_d           = s_q;
        s_d.rvalid    = 1'b0;
        s_d.rdata     = '0;
        s_d.eoi_valid = 1'b0;

        if (src_req && !s_q.pend) begin
            s_d.pend  = 1'b1;
            s_d.pprio = src_prio;
            s_d.pvec  = src_vec;
        end

        case (op)
            OP_POLL: begin
                s_d.rvalid = 1'b1;
                s_d.rdata  = pres_word;
            end
            OP_ACCEPT: begin
                s_d.rvalid = 1'b1;
                s_d.rdata  = pres_word;
                if (win_valid) begin
                    s_d.cppr = win_prio;
                    if (win_is_ipi) s_d.ipi_busy = 1'b1;
                    else            s_d.pend     = 1'b0;
                end
            end
            OP_RD_QIRR: begin
                s_d.rvalid = 1'b1;
                s_d.rdata  = {s_q.qirr, {VEC_W{1'b0}}};
            end
            OP_RD_OTHER: begin
                s_d.rvalid = 1'b1;
            end
            OP_SET_CPPR: begin
                s_d.cppr = wr_top;
            end
            OP_EOI: begin
                s_d.cppr = wr_top;
                if (wr_vec == IPI_V) begin
                    s_d.ipi_busy = 1'b0;
                end else if (wr_vec != '0) begin
                    s_d.eoi_valid = 1'b1;
                    s_d.eoi_vec   = wr_vec;
                end
            end
            OP_SET_QIRR: begin
                s_d.qirr = wr_top;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cppr      <= '0;
            s_q.qirr      <= '1;
            s_q.ipi_busy  <= 1'b0;
            s_q.pend      <= 1'b0;
            s_q.pprio     <= '0;
            s_q.pvec      <= '0;
            s_q.rdata     <= '0;
            s_q.rvalid    <= 1'b0;
            s_q.eoi_valid <= 1'b0;
            s_q.eoi_vec   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cppr      = s_q.cppr;
    assign qirr      = s_q.qirr;
    assign ipi_busy  = s_q.ipi_busy;
    assign pend      = s_q.pend;
    assign pend_prio = s_q.pprio;
    assign pend_vec  = s_q.pvec;
    assign rdata     = s_q.rdata;
    assign rvalid    = s_q.rvalid;
    assign eoi_valid = s_q.eoi_valid;
    assign eoi_vec   = s_q.eoi_vec;

    // R5: the threshold moves to the priority of the claimed request
    assert_accept_cppr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACCEPT && win_valid) |=> (s_q.cppr == $past(win_prio)));

    // R4: a poll leaves threshold and in-service mark alone
    assert_poll_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POLL) |=> ($stable(s_q.cppr) && $stable(s_q.ipi_busy)));

    // R10: the source side never sees the reserved or spurious vector
    assert_eoi_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.eoi_valid |-> (s_q.eoi_vec != IPI_V && s_q.eoi_vec != '0));

    // R2: a held request survives until it is claimed
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !(op == OP_ACCEPT && win_valid && !win_is_ipi))
        |=> (s_q.pend && $stable(s_q.pvec)));
endmodule

// File: rtl/ext_irq_presenter.sv
module ext_irq_presenter
    import ipu_pkg::*;
#(
    parameter int PRIO_W       = 8,
    parameter int VEC_W        = 24,
    parameter int ADDR_W       = 4,
    parameter int POLL_OFF     = 0,
    parameter int XIRR_OFF     = 4,
    parameter int QIRR_OFF     = 12,
    parameter int IPI_VEC      = 2,
    parameter bit IPI_WINS_TIE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [3:0]              bus_be,
    input  logic [PRIO_W+VEC_W-1:0] bus_wdata,
    output logic [PRIO_W+VEC_W-1:0] bus_rdata,
    output logic                    bus_rvalid,
    input  logic                    src_req,
    input  logic [VEC_W-1:0]        src_vec,
    input  logic [PRIO_W-1:0]       src_prio,
    output logic                    src_ready,
    output logic                    eoi_valid,
    output logic [VEC_W-1:0]        eoi_vec,
    output logic                    irq_out
);
    bus_op_e           op;
    logic [PRIO_W-1:0] cppr, qirr, pend_prio, win_prio;
    logic              ipi_busy, pend, win_valid, win_is_ipi;
    logic [VEC_W-1:0]  pend_vec, win_vec;

    ipu_bus_decode #(
        .ADDR_W(ADDR_W), .POLL_OFF(POLL_OFF),
        .XIRR_OFF(XIRR_OFF), .QIRR_OFF(QIRR_OFF)
    ) u_dec (
        .req(bus_req), .we(bus_we), .addr(bus_addr), .be(bus_be), .op(op)
    );

    ipu_arbiter #(
        .PRIO_W(PRIO_W), .VEC_W(VEC_W),
        .IPI_VEC(IPI_VEC), .IPI_WINS_TIE(IPI_WINS_TIE)
    ) u_arb (
        .cppr(cppr), .ext_pend(pend), .ext_prio(pend_prio), .ext_vec(pend_vec),
        .qirr(qirr), .ipi_busy(ipi_busy),
        .win_valid(win_valid), .win_is_ipi(win_is_ipi),
        .win_prio(win_prio), .win_vec(win_vec)
    );

    ipu_core #(
        .PRIO_W(PRIO_W), .VEC_W(VEC_W), .IPI_VEC(IPI_VEC)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(bus_wdata),
        .src_req(src_req), .src_vec(src_vec), .src_prio(src_prio),
        .win_valid(win_valid), .win_is_ipi(win_is_ipi),
        .win_prio(win_prio), .win_vec(win_vec),
        .cppr(cppr), .qirr(qirr), .ipi_busy(ipi_busy), .pend(pend),
        .pend_prio(pend_prio), .pend_vec(pend_vec),
        .rdata(bus_rdata), .rvalid(bus_rvalid),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec)
    );

    assign src_ready = !pend;
    assign irq_out   = win_valid;

    // R12: every read is answered on the next clock
    assert_read_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R12: no response without a read the cycle before
    assert_no_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);
endmodule

// File: tb/ext_irq_presenter_tb.sv
module ext_irq_presenter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        src_req = 1'b0;
    logic [23:0] src_vec = '0;
    logic [7:0]  src_prio = '0;
    logic        src_ready, eoi_valid, irq_out;
    logic [23:0] eoi_vec;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [31:0] rd_q[$];
    string       rd_tag_q[$];
    logic [23:0] eoi_q[$];

    always #2.5 clk = ~clk;

    ext_irq_presenter u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .src_req(src_req), .src_vec(src_vec), .src_prio(src_prio),
        .src_ready(src_ready), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .irq_out(irq_out)
    );

    // monitor: read responses
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            total++;
            if (rd_q.size() == 0) begin
                bad++;
                $display("FAIL R12 unexpected read response act=%08h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = rd_q.pop_front();
                t = rd_tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s read act=%08h exp=%08h", t, bus_rdata, e);
                end
            end
        end
    end

    // monitor: end-of-interrupt strobes
    always @(negedge clk) begin
        if (rst_n && eoi_valid) begin
            total++;
            if (eoi_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected eoi act=%06h exp=none", eoi_vec);
            end else begin
                logic [23:0] e;
                e = eoi_q.pop_front();
                if (eoi_vec !== e) begin
                    bad++;
                    $display("FAIL R10 eoi vector act=%06h exp=%06h", eoi_vec, e);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        rd_q.push_back(exp);
        rd_tag_q.push_back(tag);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic src(input logic [23:0] v, input logic [7:0] p);
        src_req = 1'b1; src_vec = v; src_prio = p;
        @(negedge clk);
        src_req = 1'b0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        total++;
        if (rd_q.size() != 0 || eoi_q.size() != 0) begin
            bad++;
            $display("FAIL R12 leftover expectations act=%0d exp=0", rd_q.size() + eoi_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                bad++;
                total++;
                $display("FAIL watchdog act=%0d exp<=20000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq_out}, 32'd0);
        chk("R1 src_ready", {31'b0, src_ready}, 32'd1);
        rd(4'h0, 32'h0000_0000, "R1 poll");
        rd(4'hC, 32'hFF00_0000, "R1 qirr");

        // R7 byte write threshold
        wr(4'h4, 4'b1000, 32'hFF00_0000);
        rd(4'h0, 32'hFF00_0000, "R7 poll");

        // R2 / R3 capture and present
        src(24'h123456, 8'h05);
        chk("R3 irq up", {31'b0, irq_out}, 32'd1);
        chk("R2 not ready", {31'b0, src_ready}, 32'd0);
        rd(4'h0, 32'hFF12_3456, "R4 poll");
        chk("R4 irq kept", {31'b0, irq_out}, 32'd1);
        src(24'hABCDEF, 8'h03);
        rd(4'h0, 32'hFF12_3456, "R2 ignored");

        // R5 accept
        rd(4'h4, 32'hFF12_3456, "R5 accept");
        chk("R5 irq drop", {31'b0, irq_out}, 32'd0);
        chk("R5 ready", {31'b0, src_ready}, 32'd1);
        rd(4'h0, 32'h0500_0000, "R5 cppr");

        // R10 EOI normal vector
        eoi_q.push_back(24'h123456);
        wr(4'h4, 4'b1111, 32'hFF12_3456);
        rd(4'h0, 32'hFF00_0000, "R10 cppr");

        // R3 equal priority not presented
        wr(4'h4, 4'b1000, 32'h0500_0000);
        src(24'h000077, 8'h05);
        chk("R3 equal", {31'b0, irq_out}, 32'd0);
        rd(4'h0, 32'h0500_0000, "R3 equal poll");
        wr(4'h4, 4'b1000, 32'h0600_0000);
        chk("R3 below", {31'b0, irq_out}, 32'd1);
        rd(4'h4, 32'h0600_0077, "R5 accept2");
        // R6 empty accept
        rd(4'h4, 32'h0500_0000, "R6 empty");
        rd(4'h0, 32'h0500_0000, "R6 unchanged");
        eoi_q.push_back(24'h000077);
        wr(4'h4, 4'b1111, 32'h0600_0077);

        // R8 IPI raise
        wr(4'hC, 4'b1000, 32'h0400_0000);
        chk("R8 irq", {31'b0, irq_out}, 32'd1);
        rd(4'h0, 32'h0600_0002, "R8 poll");
        rd(4'hC, 32'h0400_0000, "R12 qirr read");
        rd(4'h8, 32'h0000_0000, "R12 unmapped");

        // R9 IPI 4 beats ext 5, then R11 in-service
        src(24'h000088, 8'h05);
        rd(4'h0, 32'h0600_0002, "R9 lower wins");
        rd(4'h4, 32'h0600_0002, "R5 accept ipi");
        chk("R3 ext masked", {31'b0, irq_out}, 32'd0);
        wr(4'h4, 4'b1000, 32'hFF00_0000);
        rd(4'h0, 32'hFF00_0088, "R11 ipi hidden");
        rd(4'h4, 32'hFF00_0088, "R5 accept ext");
        wr(4'h4, 4'b1111, 32'h0400_0002);   // no strobe expected (R10)
        @(negedge clk);
        chk("R11 not below", {31'b0, irq_out}, 32'd0);
        eoi_q.push_back(24'h000088);
        wr(4'h4, 4'b1111, 32'hFF00_0088);
        rd(4'h0, 32'hFF00_0002, "R11 re-presented");
        wr(4'hC, 4'b1000, 32'hFF00_0000);
        chk("R8 withdraw irq", {31'b0, irq_out}, 32'd0);
        rd(4'h0, 32'hFF00_0000, "R8 withdraw");

        // R9 tie and ordering
        src(24'h000099, 8'h05);
        wr(4'hC, 4'b1000, 32'h0500_0000);
        rd(4'h0, 32'hFF00_0002, "R9 tie");
        wr(4'hC, 4'b1000, 32'h0600_0000);
        rd(4'h0, 32'hFF00_0099, "R9 ext lower");

        // R7 other byte enables ignored
        wr(4'h4, 4'b0001, 32'h0000_0000);
        wr(4'h4, 4'b0100, 32'h0000_0000);
        rd(4'h0, 32'hFF00_0099, "R7 ignored");
        eoi_q.push_back(24'h000055);
        wr(4'h4, 4'b1111, 32'h0300_0055);
        chk("R10 cppr from eoi", {31'b0, irq_out}, 32'd0);
        wr(4'h4, 4'b1111, 32'hFF00_0000);   // vector 0: no strobe
        rd(4'h0, 32'hFF00_0099, "R10 vec0");

        finish_run();
    end
endmodule